// File: doc/BRIEF.md
# Transmit Channel Start/Stop and Drain Sequencer

This block decides when one transmit channel runs and when it stops. It sits between a serial data port and the interpolating datapath. While the channel's digital enable is high, it asks the port for 16-bit words and holds up to two of them in a small buffer. It hands the downstream logic one sample for each sample strobe.

When the port has never delivered anything, the sequencer supplies zero samples. When the buffer runs dry after data has arrived, it repeats the last word it supplied and raises a sticky underrun flag. After the enable is withdrawn, it stops asking for words and keeps supplying what is still buffered. The first strobe that finds the buffer empty ends the drain. The sequencer then sweeps every address of the interpolation sample RAM, writing zeros. Only after that sweep does it report idle. A new enable that arrives during the sweep waits until the sweep is over.

Top module: `tx_drain_ctrl`

## Requirements
- R1: After reset, `idle`=1 and `word_req`, `ram_we`, `urun` and `smp_vld` are all 0.
- R2: While idle, raising `chan_en` drops `idle` in the same cycle. From the next cycle on, `word_req` is high whenever `port_en`=1 and the buffer is not full.
- R3: A word is accepted on a clock edge where `word_vld` and `word_req` are both high. The buffer holds at most 2 words, and `word_req` is 0 while it is full.
- R4: In the running and draining phases, each `smp_stb` gives `smp_vld`=1 one cycle later. `smp_out` then carries the oldest buffered word, so words come out in arrival order.
- R5: If no word has been supplied since the channel was enabled, a strobe that finds the buffer empty yields 0x0000 and leaves `urun` unchanged.
- R6: If a word has already been supplied, a strobe that finds the buffer empty repeats the last supplied word and sets `urun`. `urun` stays 1 until `urun_clr` is high on a clock edge with no new underrun.
- R7: While `chan_en`=0, `word_req` is 0. After `chan_en` falls, the words already buffered are still supplied. The first strobe that finds the buffer empty ends the drain.
- R8: The drain is followed by exactly 128 consecutive cycles with `ram_we`=1. During them `ram_addr` steps 0,1,...,127, `ram_wdata`=0 and `idle`=0.
- R9: `idle` returns to 1 in the cycle right after the last RAM write, provided `chan_en`=0.
- R10: Raising `chan_en` during the RAM sweep causes no word request until the sweep ends. The channel runs again two cycles after the last RAM write, when `word_req` rises if `port_en`=1.
- R11: Re-enabling after a sweep starts from a clean state: the buffer is empty and the first empty-buffer strobes yield 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel digital enable |
| port_en | input | 1 | Serial port enabled |
| word_req | output | 1 | Request for a word from the port |
| word_vld | input | 1 | Port presents a word this cycle |
| word_data | input | 16 | Word from the port |
| smp_stb | input | 1 | Downstream sample strobe |
| smp_vld | output | 1 | Sample valid, one cycle after strobe |
| smp_out | output | 16 | Sample to the datapath |
| urun | output | 1 | Sticky underrun flag |
| urun_clr | input | 1 | Clears the underrun flag |
| idle | output | 1 | Channel idle status |
| ram_we | output | 1 | Sample RAM write enable during sweep |
| ram_addr | output | 7 | Sample RAM address during sweep |
| ram_wdata | output | 16 | Sample RAM write data (zero) |

## Verification
The checker watches several rules on every cycle:
- no request while disabled, while the buffer is full or while the sweep runs;
- during the sweep, addresses start at zero and advance by one, and idle stays low;
- idle rises when the sweep ends with the enable low;
- a valid sample always follows a strobe;
- the underrun flag holds until it is cleared.

Only the bench scenarios can show the rules that involve data:
- the arrival order of sample values;
- the choice between zeros and the repeated last word;
- that buffered words survive a disable;
- that the sweep lasts exactly 128 cycles;
- the exact cycle at which a held-off re-enable starts requesting.

// File: rtl/tx_drain_pkg.sv
package tx_drain_pkg;

    localparam int SMP_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_CLEAR = 2'd3
    } chan_state_t;

    typedef struct packed {
        logic [SMP_W-1:0] data;
        logic             short_fall;
    } pick_t;

    // Choose the sample for one strobe: buffered head, repeated word, or zero.
    function automatic pick_t pick_sample(input logic have_word,
                                          input logic seen_word,
                                          input logic [SMP_W-1:0] head,
                                          input logic [SMP_W-1:0] held);
        pick_t r;
        if (have_word) begin
            r.data       = head;
            r.short_fall = 1'b0;
        end else if (seen_word) begin
            r.data       = held;
            r.short_fall = 1'b1;
        end else begin
            r.data       = '0;
            r.short_fall = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_word_buf.sv
module tx_word_buf
    import tx_drain_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [SMP_W-1:0] din,
    input  logic             pop,
    output logic [SMP_W-1:0] head,
    output logic             empty,
    output logic             full
);

    logic [SMP_W-1:0] slot_q [DEPTH];
    logic [PW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign head    = slot_q[rp_q];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= step_ptr(wp_q);
            if (do_pop)  rp_q <= step_ptr(rp_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) slot_q[i] <= '0;
            else if (do_push && !flush && wp_q == PW'(i)) slot_q[i] <= din;
        end
    end

endmodule

// File: rtl/tx_ram_sweep.sv
module tx_ram_sweep #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [AW-1:0] addr,
    output logic          last
);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || !run) addr_q <= '0;
        else             addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
    assign last = run && (addr_q == AW'(DEPTH - 1));

endmodule

// File: rtl/tx_drain_ctrl.sv
module tx_drain_ctrl
    import tx_drain_pkg::*;
#(
    parameter int RAM_DEPTH = 128,
    parameter int BUF_DEPTH = 2,
    localparam int AW = $clog2(RAM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic             port_en,
    output logic             word_req,
    input  logic             word_vld,
    input  logic [SMP_W-1:0] word_data,
    input  logic             smp_stb,
    output logic             smp_vld,
    output logic [SMP_W-1:0] smp_out,
    output logic             urun,
    input  logic             urun_clr,
    output logic             idle,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [SMP_W-1:0] ram_wdata
);

    chan_state_t      st_q, st_nx;
    logic             buf_empty, buf_full;
    logic [SMP_W-1:0] buf_head;
    logic             seen_q;
    logic [SMP_W-1:0] held_q;
    logic             sweep_last;
    logic             active, take, push, pop, flush;
    pick_t            pk;

    assign active   = (st_q == ST_RUN) || (st_q == ST_DRAIN);
    assign take     = smp_stb && active;
    assign word_req = (st_q == ST_RUN) && chan_en && port_en && !buf_full;
    assign push     = word_vld && word_req;
    assign pop      = take && !buf_empty;
    assign flush    = take && buf_empty && (st_q == ST_DRAIN);
    assign pk       = pick_sample(!buf_empty, seen_q, buf_head, held_q);

    tx_word_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (push),
        .din   (word_data),
        .pop   (pop),
        .head  (buf_head),
        .empty (buf_empty),
        .full  (buf_full)
    );

    tx_ram_sweep #(.DEPTH(RAM_DEPTH)) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .run  (st_q == ST_CLEAR),
        .addr (ram_addr),
        .last (sweep_last)
    );

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:  if (chan_en)    st_nx = ST_RUN;
            ST_RUN:   if (!chan_en)   st_nx = ST_DRAIN;
            ST_DRAIN: if (flush)      st_nx = ST_CLEAR;
            ST_CLEAR: if (sweep_last) st_nx = ST_IDLE;
            default:                  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nx;
    end

    // Last supplied word and whether any word has been supplied since enable.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            seen_q <= 1'b0;
            held_q <= '0;
        end else if (pop) begin
            seen_q <= 1'b1;
            held_q <= buf_head;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_vld <= 1'b0;
            smp_out <= '0;
        end else begin
            smp_vld <= take;
            if (take) smp_out <= pk.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          urun <= 1'b0;
        else if (take && pk.short_fall)   urun <= 1'b1;
        else if (urun_clr)                urun <= 1'b0;
    end

    assign idle      = (st_q == ST_IDLE) && !chan_en;
    assign ram_we    = (st_q == ST_CLEAR);
    assign ram_wdata = '0;

endmodule

module tx_drain_ctrl_chk #(
    parameter int RAM_DEPTH = 128,
    localparam int AW = $clog2(RAM_DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          chan_en,
    input logic          word_req,
    input logic          buf_full,
    input logic          smp_stb,
    input logic          smp_vld,
    input logic          urun,
    input logic          urun_clr,
    input logic          idle,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr
);

    a_r7_no_req_disabled: assert property (@(posedge clk) disable iff (rst)
        !chan_en |-> !word_req);

    a_r3_no_req_full: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> !word_req);

    a_r10_no_req_in_sweep: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !word_req);

    a_r8_idle_low_in_sweep: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !idle);

    a_r8_sweep_starts_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we) |-> ram_addr == '0);

    a_r8_addr_steps: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> ram_addr == AW'($past(ram_addr) + 1'b1));

    a_r9_idle_after_sweep: assert property (@(posedge clk) disable iff (rst)
        ($fell(ram_we) && !chan_en) |-> idle);

    a_r4_vld_after_stb: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> $past(smp_stb));

    a_r6_urun_sticky: assert property (@(posedge clk) disable iff (rst)
        (urun && !urun_clr) |=> urun);

endmodule

bind tx_drain_ctrl tx_drain_ctrl_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (.*);

// File: tb/tx_drain_ctrl_test.sv
module tx_drain_ctrl_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0, port_en = 1'b0;
    logic        word_vld = 1'b0, smp_stb = 1'b0, urun_clr = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_req, smp_vld, urun, idle, ram_we;
    logic [15:0] smp_out, ram_wdata;
    logic [6:0]  ram_addr;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    tx_drain_ctrl uut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .port_en(port_en),
        .word_req(word_req), .word_vld(word_vld), .word_data(word_data),
        .smp_stb(smp_stb), .smp_vld(smp_vld), .smp_out(smp_out),
        .urun(urun), .urun_clr(urun_clr), .idle(idle),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    function automatic logic [15:0] wval(input int i);
        return 16'h1000 + 16'(i * 16'h0135);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_word(input logic [15:0] w, input string tag);
        word_vld  = 1'b1;
        word_data = w;
        #1;
        chk(tag, {31'b0, word_req}, 32'd1);
        step();
        word_vld = 1'b0;
        #1;
    endtask

    task automatic strobe(input logic [15:0] exp, input string tag);
        smp_stb = 1'b1;
        step();
        smp_stb = 1'b0;
        #1;
        chk({tag, " vld"}, {31'b0, smp_vld}, 32'd1);
        chk({tag, " data"}, {16'b0, smp_out}, {16'b0, exp});
    endtask

    task automatic sweep(input bit reenable, input string tag);
        for (int i = 0; i < 128; i++) begin
            chk({tag, " we"}, {31'b0, ram_we}, 32'd1);
            chk({tag, " addr"}, {25'b0, ram_addr}, i);
            chk({tag, " wdata"}, {16'b0, ram_wdata}, 32'd0);
            chk({tag, " idle"}, {31'b0, idle}, 32'd0);
            if (reenable) chk("R10 req held in sweep", {31'b0, word_req}, 32'd0);
            if (reenable && i == 60) chan_en = 1'b1;
            step();
            #1;
        end
        chk({tag, " we end"}, {31'b0, ram_we}, 32'd0);
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 idle", {31'b0, idle}, 32'd1);
        chk("R1 req", {31'b0, word_req}, 32'd0);
        chk("R1 we", {31'b0, ram_we}, 32'd0);
        chk("R1 urun", {31'b0, urun}, 32'd0);
        chk("R1 vld", {31'b0, smp_vld}, 32'd0);

        // R2 idle falls same cycle; R5 zeros with port off
        step();
        chan_en = 1'b1;
        #1;
        chk("R2 idle same cycle", {31'b0, idle}, 32'd0);
        step();
        #1;
        chk("R2 no req port off", {31'b0, word_req}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            strobe(16'h0000, "R5 zero sample");
            chk("R5 no urun", {31'b0, urun}, 32'd0);
        end

        // R2/R3 fill, full stops requests; R4 order
        port_en = 1'b1;
        #1;
        chk("R2 req with port", {31'b0, word_req}, 32'd1);
        push_word(wval(0), "R3 accept0");
        push_word(wval(1), "R3 accept1");
        chk("R3 full no req", {31'b0, word_req}, 32'd0);
        for (int k = 0; k < 10; k++) begin
            strobe(wval(k), "R4 order");
            push_word(wval(k + 2), "R3 refill");
            chk("R3 full again", {31'b0, word_req}, 32'd0);
        end

        // R6 port stops: drain then repeat last with underrun
        port_en = 1'b0;
        strobe(wval(10), "R6 buffered a");
        strobe(wval(11), "R6 buffered b");
        chk("R6 no urun yet", {31'b0, urun}, 32'd0);
        for (int k = 0; k < 3; k++) strobe(wval(11), "R6 repeat");
        chk("R6 urun set", {31'b0, urun}, 32'd1);
        step();
        step();
        #1;
        chk("R6 urun sticky", {31'b0, urun}, 32'd1);
        urun_clr = 1'b1;
        step();
        urun_clr = 1'b0;
        #1;
        chk("R6 urun cleared", {31'b0, urun}, 32'd0);

        // R7 drain after disable
        port_en = 1'b1;
        #1;
        push_word(wval(20), "R7 fill a");
        push_word(wval(21), "R7 fill b");
        strobe(wval(20), "R7 pre");
        push_word(wval(22), "R7 fill c");
        chan_en = 1'b0;
        #1;
        chk("R7 req drops", {31'b0, word_req}, 32'd0);
        chk("R7 not idle", {31'b0, idle}, 32'd0);
        strobe(wval(21), "R7 drain a");
        strobe(wval(22), "R7 drain b");
        chk("R7 not sweeping", {31'b0, ram_we}, 32'd0);
        strobe(wval(22), "R7 drain end");
        sweep(1'b0, "R8 sweep1");
        chk("R9 idle after sweep", {31'b0, idle}, 32'd1);
        chk("R9 req low", {31'b0, word_req}, 32'd0);

        // R11 clean restart with port off, then second sweep with held-off enable
        urun_clr = 1'b1;
        step();
        urun_clr = 1'b0;
        port_en  = 1'b0;
        chan_en  = 1'b1;
        step();
        #1;
        strobe(16'h0000, "R11 zero after restart");
        chk("R11 no urun", {31'b0, urun}, 32'd0);
        port_en = 1'b1;
        #1;
        push_word(wval(30), "R11 accept");
        chan_en = 1'b0;
        strobe(wval(30), "R11 drain");
        strobe(wval(30), "R11 drain end");
        sweep(1'b1, "R8 sweep2");
        chk("R10 idle low at end", {31'b0, idle}, 32'd0);
        chk("R10 req not yet", {31'b0, word_req}, 32'd0);
        step();
        #1;
        chk("R10 req after sweep", {31'b0, word_req}, 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule